// File: doc/BRIEF.md
# Lockable TLB with Round-Robin Victim Pointer

This block is a small fully associative translation cache for a device-side address translator. Every slot pairs a tag half with a data half. The tag half holds the virtual start, a two-bit page size code, a valid bit and a preserve bit. The data half holds the physical base and the attribute bits. Slots of different page sizes can sit side by side in the same array. A lookup port takes a device address and returns hit, translated address and attributes combinationally, based on the contents of the array before the next clock edge.

Software controls replacement through a lock register with two fields. The floor index marks the bottom region of preserved slots. The victim index points at the next slot to replace. A command port runs six operations: no-op, set lock, load, read, flush one and flush all. Ordinary loads fill the slot at the victim index and advance it round-robin. When the victim index reaches the entry count it wraps back to the floor, so preserved slots are never overwritten by ordinary loads. A preserved load goes to the floor slot and raises the floor by one. Software can scan every slot by writing the victim field and then issuing a read.

A command sequencer has four states: `ST_IDLE`, `ST_COMMIT`, `ST_SHOW` and `ST_REFUSE`. A load moves `ST_IDLE -> ST_COMMIT`, or `ST_IDLE -> ST_REFUSE` when the floor already equals the entry count. A read moves `ST_IDLE -> ST_SHOW`. `ST_COMMIT`, `ST_SHOW` and `ST_REFUSE` each return to `ST_IDLE` after one cycle. Set lock, flush one and flush all complete inside `ST_IDLE` in a single edge. Commands are only accepted while `ctl_ready` is high.

Top module: `lockable_tlb`

## Requirements
- R1: After reset, floor and victim are both 0, every slot is invalid, `ctl_ready` is 1, and `ctl_busy` and `rd_valid` are 0.
- R2: A load command (op code 2) with `ld_prsvd`=0 writes the presented entry, marked valid, into the slot at the victim index. The victim index then increases by one. `ctl_ready` drops for exactly one cycle after the accepting edge.
- R3: When the incremented victim index reaches NUM_ENTRIES, it becomes the floor index instead of zero.
- R4: A load with `ld_prsvd`=1 writes into the slot at the floor index. The floor rises by one, and the victim becomes the old floor plus one, wrapped as in R3.
- R5: While the floor equals NUM_ENTRIES, any load is refused. `ctl_busy` is 1 for one cycle, and neither the lock fields nor any slot change.
- R6: Set lock (op code 1) loads the floor from `ctl_floor_wr` and the victim from `ctl_vict_wr` in one edge.
- R7: Read (op code 3) presents the slot at the victim index on the `rd_*` outputs, with `rd_valid` high for one cycle after the accepting edge.
- R8: Flush one (op code 4) clears only the valid bit of the slot at the victim index and leaves both lock fields unchanged.
- R9: Flush all (op code 5) clears every valid bit and sets both the floor and the victim to 0.
- R10: The size code gives the page size: 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB. A lookup hits a valid slot when start <= address < start + page size.
- R11: The translated address is the physical base with its in-page bits replaced by the in-page bits of the lookup address. `lk_attr` is the attributes of the matching slot.
- R12: When several slots match, the lowest slot index supplies the result.
- R13: A lookup reflects the array as it stands before the current edge. A slot written or flushed at an edge changes the lookup result only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_op | input | 3 | Command code: 0 none, 1 set lock, 2 load, 3 read, 4 flush one, 5 flush all |
| ctl_floor_wr | input | IDX_W | Floor value for set lock |
| ctl_vict_wr | input | IDX_W | Victim value for set lock |
| ld_tag | input | 32 | Virtual start of the entry to load |
| ld_size | input | 2 | Page size code of the entry to load |
| ld_prsvd | input | 1 | Load as a preserved entry |
| ld_pbase | input | 32 | Physical base of the entry to load |
| ld_attr | input | 4 | Attributes of the entry to load |
| ctl_ready | output | 1 | Sequencer is idle and accepts a command |
| ctl_busy | output | 1 | One-cycle pulse: a load was refused |
| lock_floor | output | IDX_W | Current floor index |
| lock_vict | output | IDX_W | Current victim index |
| rd_valid | output | 1 | Read data is presented |
| rd_tag | output | 32 | Read slot virtual start |
| rd_size | output | 2 | Read slot size code |
| rd_entry_valid | output | 1 | Read slot valid bit |
| rd_prsvd | output | 1 | Read slot preserve bit |
| rd_pbase | output | 32 | Read slot physical base |
| rd_attr | output | 4 | Read slot attributes |
| lk_va | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated address |
| lk_attr | output | 4 | Attributes of the matching slot |

## Verification
Lookup and slot modification can land in the same cycle. A load can commit a slot, or a flush can clear one, while a lookup is aimed at that very slot. The bench holds the lookup address fixed across the committing edge. It checks the result just before that edge, where it must still show the old contents: a miss before a load, a hit before a flush. It checks again just after the edge, where the new contents must appear.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ADDR_W = 32;
    localparam int ATTR_W = 4;

    typedef enum logic [1:0] {
        PG_1M  = 2'b00,
        PG_64K = 2'b01,
        PG_4K  = 2'b10,
        PG_16M = 2'b11
    } pgsz_e;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_SET_LOCK  = 3'd1,
        OP_LOAD      = 3'd2,
        OP_READ      = 3'd3,
        OP_FLUSH_ONE = 3'd4,
        OP_FLUSH_ALL = 3'd5
    } ctl_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        pgsz_e             size;
        logic              valid;
        logic              prsvd;
        logic [ADDR_W-1:0] pbase;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    // In-page offset mask for a given size code
    function automatic logic [ADDR_W-1:0] offset_mask(input pgsz_e s);
        logic [ADDR_W-1:0] m;
        unique case (s)
            PG_1M:   m = ADDR_W'(32'h000F_FFFF);
            PG_64K:  m = ADDR_W'(32'h0000_FFFF);
            PG_4K:   m = ADDR_W'(32'h0000_0FFF);
            PG_16M:  m = ADDR_W'(32'h00FF_FFFF);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t wr_entry,
    input  logic       clr_one,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic       clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_entry_t peek,
    output tlb_entry_t slots [NUM_ENTRIES]
);
    localparam int SLOT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    tlb_entry_t ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (clr_all)
                    ent_q[i].valid <= 1'b0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    ent_q[i] <= wr_entry;
                else if (clr_one && clr_idx == IDX_W'(i))
                    ent_q[i].valid <= 1'b0;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            assign slots[g]     = ent_q[g];
            assign valid_vec[g] = ent_q[g].valid;
        end
    endgenerate

    always_comb begin
        if (rd_idx < IDX_W'(NUM_ENTRIES))
            peek = ent_q[rd_idx[SLOT_W-1:0]];
        else
            peek = '0;
    end

    // R9: a global flush leaves no valid slot behind
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_vec == '0));

    // R2: a written slot is valid afterwards
    p_write_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && wr_idx < IDX_W'(NUM_ENTRIES)) |=> $countones(valid_vec) >= 1);

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  tlb_entry_t        slots [NUM_ENTRIES],
    input  logic [ADDR_W-1:0] va,
    output logic              hit,
    output logic [ADDR_W-1:0] pa,
    output logic [ATTR_W-1:0] attr
);
    logic [NUM_ENTRIES-1:0] hit_vec;
    tlb_entry_t             sel;
    logic [ADDR_W-1:0]      sel_mask;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            logic [ADDR_W-1:0] m;
            assign m          = offset_mask(slots[g].size);
            assign hit_vec[g] = slots[g].valid && (((va ^ slots[g].tag) & ~m) == '0);
        end
    endgenerate

    // Lowest index wins: scan from the top so the lowest overwrites last
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                sel = slots[i];
            end
        end
        sel_mask = offset_mask(sel.size);
        pa       = hit ? ((sel.pbase & ~sel_mask) | (va & sel_mask)) : '0;
        attr     = hit ? sel.attr : '0;
    end

endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [IDX_W-1:0] floor_wr,
    input  logic [IDX_W-1:0] vict_wr,
    input  tlb_entry_t       ld_entry,
    input  tlb_entry_t       peek,
    output logic [IDX_W-1:0] floor_q,
    output logic [IDX_W-1:0] vict_q,
    output logic             ready,
    output logic             busy,
    output logic             rd_valid,
    output tlb_entry_t       rd_entry,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output tlb_entry_t       wr_entry,
    output logic             clr_one,
    output logic             clr_all,
    output logic [IDX_W-1:0] rd_idx
);
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SHOW   = 2'd2,
        ST_REFUSE = 2'd3
    } state_e;

    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_ENTRIES);

    state_e           state_q, state_d;
    ctl_op_e          op_e;
    tlb_entry_t       hold_q;
    logic             full;
    logic [IDX_W-1:0] widx, floor_nx, vict_inc, vict_nx;
    logic             idle;

    assign op_e = ctl_op_e'(op);
    assign full = (floor_q == LIMIT);
    assign idle = (state_q == ST_IDLE);

    // Placement and pointer advance for the held load
    assign widx     = hold_q.prsvd ? floor_q : vict_q;
    assign floor_nx = hold_q.prsvd ? floor_q + IDX_W'(1) : floor_q;
    assign vict_inc = widx + IDX_W'(1);
    assign vict_nx  = (vict_inc >= LIMIT) ? floor_nx : vict_inc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                case (op_e)
                    OP_LOAD: state_d = full ? ST_REFUSE : ST_COMMIT;
                    OP_READ: state_d = ST_SHOW;
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_SHOW:   state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Lock fields, load holding register, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            floor_q  <= '0;
            vict_q   <= '0;
            hold_q   <= '0;
            rd_entry <= '0;
        end else if (idle) begin
            case (op_e)
                OP_SET_LOCK: begin
                    floor_q <= floor_wr;
                    vict_q  <= vict_wr;
                end
                OP_LOAD: if (!full) hold_q <= ld_entry;
                OP_READ: rd_entry <= peek;
                OP_FLUSH_ALL: begin
                    floor_q <= '0;
                    vict_q  <= '0;
                end
                default: ;
            endcase
        end else if (state_q == ST_COMMIT) begin
            floor_q <= floor_nx;
            vict_q  <= vict_nx;
        end
    end

    // Outputs
    always_comb begin
        ready          = idle;
        busy           = (state_q == ST_REFUSE);
        rd_valid       = (state_q == ST_SHOW);
        wr_en          = (state_q == ST_COMMIT);
        wr_idx         = widx;
        wr_entry       = hold_q;
        wr_entry.valid = 1'b1;
        clr_one        = idle && (op_e == OP_FLUSH_ONE);
        clr_all        = idle && (op_e == OP_FLUSH_ALL);
        rd_idx         = vict_q;
    end

    p_set_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && op_e == OP_SET_LOCK) |=> (floor_q == $past(floor_wr) && vict_q == $past(vict_wr)));

    p_flush_all_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && op_e == OP_FLUSH_ALL) |=> (floor_q == '0 && vict_q == '0));

    p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && op_e == OP_LOAD && full) |=> (busy && $stable(floor_q) && $stable(vict_q)));

    p_floor_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && hold_q.prsvd) |=> (floor_q == $past(floor_q) + IDX_W'(1)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !hold_q.prsvd && vict_q == LIMIT - IDX_W'(1))
        |=> (vict_q == $past(floor_q)));

    p_flush_one_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && op_e == OP_FLUSH_ONE) |=> ($stable(floor_q) && $stable(vict_q)));

endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 8,
    localparam int IDX_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ctl_op,
    input  logic [IDX_W-1:0]   ctl_floor_wr,
    input  logic [IDX_W-1:0]   ctl_vict_wr,
    input  logic [ADDR_W-1:0]  ld_tag,
    input  logic [1:0]         ld_size,
    input  logic               ld_prsvd,
    input  logic [ADDR_W-1:0]  ld_pbase,
    input  logic [ATTR_W-1:0]  ld_attr,
    output logic               ctl_ready,
    output logic               ctl_busy,
    output logic [IDX_W-1:0]   lock_floor,
    output logic [IDX_W-1:0]   lock_vict,
    output logic               rd_valid,
    output logic [ADDR_W-1:0]  rd_tag,
    output logic [1:0]         rd_size,
    output logic               rd_entry_valid,
    output logic               rd_prsvd,
    output logic [ADDR_W-1:0]  rd_pbase,
    output logic [ATTR_W-1:0]  rd_attr,
    input  logic [ADDR_W-1:0]  lk_va,
    output logic               lk_hit,
    output logic [ADDR_W-1:0]  lk_pa,
    output logic [ATTR_W-1:0]  lk_attr
);
    tlb_entry_t       ld_entry, peek, rd_entry, wr_entry;
    tlb_entry_t       slots [NUM_ENTRIES];
    logic             wr_en, clr_one, clr_all;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        ld_entry       = '0;
        ld_entry.tag   = ld_tag;
        ld_entry.size  = pgsz_e'(ld_size);
        ld_entry.prsvd = ld_prsvd;
        ld_entry.pbase = ld_pbase;
        ld_entry.attr  = ld_attr;
    end

    tlb_lock_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ctl_op),
        .floor_wr (ctl_floor_wr),
        .vict_wr  (ctl_vict_wr),
        .ld_entry (ld_entry),
        .peek     (peek),
        .floor_q  (lock_floor),
        .vict_q   (lock_vict),
        .ready    (ctl_ready),
        .busy     (ctl_busy),
        .rd_valid (rd_valid),
        .rd_entry (rd_entry),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .clr_one  (clr_one),
        .clr_all  (clr_all),
        .rd_idx   (rd_idx)
    );

    tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .clr_one  (clr_one),
        .clr_idx  (rd_idx),
        .clr_all  (clr_all),
        .rd_idx   (rd_idx),
        .peek     (peek),
        .slots    (slots)
    );

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .slots (slots),
        .va    (lk_va),
        .hit   (lk_hit),
        .pa    (lk_pa),
        .attr  (lk_attr)
    );

    assign rd_tag         = rd_entry.tag;
    assign rd_size        = rd_entry.size;
    assign rd_entry_valid = rd_entry.valid;
    assign rd_prsvd       = rd_entry.prsvd;
    assign rd_pbase       = rd_entry.pbase;
    assign rd_attr        = rd_entry.attr;

endmodule

// File: tb/sim_lockable_tlb.sv
`timescale 1ns/1ps
module sim_lockable_tlb;
    import tlb_pkg::*;

    localparam int N     = 8;
    localparam int IDX_W = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ctl_op = 3'd0;
    logic [IDX_W-1:0] ctl_floor_wr = '0, ctl_vict_wr = '0;
    logic [31:0] ld_tag = '0, ld_pbase = '0, lk_va = '0;
    logic [1:0] ld_size = '0;
    logic ld_prsvd = 1'b0;
    logic [3:0] ld_attr = '0;
    logic ctl_ready, ctl_busy, rd_valid, rd_entry_valid, rd_prsvd, lk_hit;
    logic [IDX_W-1:0] lock_floor, lock_vict;
    logic [31:0] rd_tag, rd_pbase, lk_pa;
    logic [1:0] rd_size;
    logic [3:0] rd_attr, lk_attr;

    int n_chk = 0;
    int n_fail = 0;
    logic saw_busy, saw_rd;
    logic [31:0] cap_tag, cap_pbase;
    logic [1:0] cap_size;
    logic cap_valid, cap_prsvd;

    always #2.5 clk = ~clk;

    lockable_tlb #(.NUM_ENTRIES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op),
        .ctl_floor_wr(ctl_floor_wr), .ctl_vict_wr(ctl_vict_wr),
        .ld_tag(ld_tag), .ld_size(ld_size), .ld_prsvd(ld_prsvd),
        .ld_pbase(ld_pbase), .ld_attr(ld_attr),
        .ctl_ready(ctl_ready), .ctl_busy(ctl_busy),
        .lock_floor(lock_floor), .lock_vict(lock_vict),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_size(rd_size),
        .rd_entry_valid(rd_entry_valid), .rd_prsvd(rd_prsvd),
        .rd_pbase(rd_pbase), .rd_attr(rd_attr),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op);
        @(negedge clk);
        ctl_op = op;
        @(posedge clk);
        @(negedge clk);
        ctl_op    = 3'd0;
        saw_busy  = ctl_busy;
        saw_rd    = rd_valid;
        cap_tag   = rd_tag;
        cap_pbase = rd_pbase;
        cap_size  = rd_size;
        cap_valid = rd_entry_valid;
        cap_prsvd = rd_prsvd;
        while (!ctl_ready) @(negedge clk);
    endtask

    task automatic set_lock(input int f, input int v);
        ctl_floor_wr = IDX_W'(f);
        ctl_vict_wr  = IDX_W'(v);
        run_op(OP_SET_LOCK);
    endtask

    task automatic load(input logic [31:0] tag, input logic [1:0] sz, input logic pr,
                        input logic [31:0] pb, input logic [3:0] at);
        ld_tag = tag; ld_size = sz; ld_prsvd = pr; ld_pbase = pb; ld_attr = at;
        run_op(OP_LOAD);
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic h,
                        input logic [31:0] pa, input logic [3:0] at);
        @(negedge clk);
        lk_va = va;
        #1;
        chk(req, {31'd0, lk_hit}, {31'd0, h});
        if (h) begin
            chk(req, lk_pa, pa);
            chk(req, {28'd0, lk_attr}, {28'd0, at});
        end
    endtask

    task automatic chk_lock(input string req, input int f, input int v);
        chk(req, 32'(lock_floor), 32'(f));
        chk(req, 32'(lock_vict), 32'(v));
    endtask

    task automatic t_reset;
        chk_lock("R1 lock", 0, 0);
        chk("R1 ready", {31'd0, ctl_ready}, 32'd1);
        chk("R1 busy", {31'd0, ctl_busy}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        look("R1 empty", 32'h1000_3abc, 1'b0, '0, '0);
    endtask

    task automatic t_basic_load;
        load(32'h1000_3000, 2'd2, 1'b0, 32'h8000_5000, 4'd3);
        chk_lock("R2 vict advance", 0, 1);
        look("R2 R11 4K hit", 32'h1000_3abc, 1'b1, 32'h8000_5abc, 4'd3);
        look("R10 4K last", 32'h1000_3fff, 1'b1, 32'h8000_5fff, 4'd3);
        look("R10 4K end", 32'h1000_4000, 1'b0, '0, '0);
        look("R10 4K below", 32'h1000_2fff, 1'b0, '0, '0);
    endtask

    task automatic t_mixed;
        load(32'h2000_0000, 2'd3, 1'b0, 32'h4000_0000, 4'd5);
        load(32'h0030_0000, 2'd0, 1'b0, 32'h0150_0000, 4'd6);
        load(32'h5555_0000, 2'd1, 1'b0, 32'h0777_0000, 4'd7);
        chk_lock("R2 vict four", 0, 4);
        look("R10 R11 16M", 32'h20ab_cdef, 1'b1, 32'h40ab_cdef, 4'd5);
        look("R10 R11 1M", 32'h0034_5678, 1'b1, 32'h0154_5678, 4'd6);
        look("R10 R11 64K", 32'h5555_1234, 1'b1, 32'h0777_1234, 4'd7);
        look("R10 16M end", 32'h2100_0000, 1'b0, '0, '0);
        look("R10 64K end", 32'h5556_0000, 1'b0, '0, '0);
    endtask

    task automatic t_read_scan;
        set_lock(0, 2);
        chk_lock("R6 set lock", 0, 2);
        run_op(OP_READ);
        chk("R7 rd_valid", {31'd0, saw_rd}, 32'd1);
        chk("R7 tag", cap_tag, 32'h0030_0000);
        chk("R7 pbase", cap_pbase, 32'h0150_0000);
        chk("R7 size", {30'd0, cap_size}, 32'd0);
        chk("R7 valid", {31'd0, cap_valid}, 32'd1);
        set_lock(0, 1);
        run_op(OP_READ);
        chk("R7 tag slot1", cap_tag, 32'h2000_0000);
        chk("R7 size slot1", {30'd0, cap_size}, 32'd3);
    endtask

    task automatic t_flush_one;
        set_lock(0, 3);
        run_op(OP_FLUSH_ONE);
        chk_lock("R8 lock kept", 0, 3);
        look("R8 flushed", 32'h5555_1234, 1'b0, '0, '0);
        look("R8 other kept", 32'h20ab_cdef, 1'b1, 32'h40ab_cdef, 4'd5);
    endtask

    task automatic t_flush_all;
        run_op(OP_FLUSH_ALL);
        chk_lock("R9 lock zero", 0, 0);
        look("R9 miss a", 32'h1000_3abc, 1'b0, '0, '0);
        look("R9 miss b", 32'h20ab_cdef, 1'b0, '0, '0);
        run_op(OP_READ);
        chk("R9 slot0 invalid", {31'd0, cap_valid}, 32'd0);
    endtask

    task automatic t_preserve;
        load(32'h1000_3000, 2'd2, 1'b0, 32'h8000_5000, 4'd3);
        load(32'h1100_0000, 2'd2, 1'b0, 32'h8100_0000, 4'd4);
        load(32'h6000_0000, 2'd2, 1'b1, 32'h9000_0000, 4'd9);
        chk_lock("R4 floor rise", 1, 1);
        look("R4 preserved hit", 32'h6000_0010, 1'b1, 32'h9000_0010, 4'd9);
        look("R4 slot0 replaced", 32'h1000_3abc, 1'b0, '0, '0);
        set_lock(1, 0);
        run_op(OP_READ);
        chk("R4 prsvd bit", {31'd0, cap_prsvd}, 32'd1);
        chk("R4 slot0 tag", cap_tag, 32'h6000_0000);
    endtask

    task automatic t_wrap;
        set_lock(2, 7);
        load(32'h7000_0000, 2'd1, 1'b0, 32'h0a00_0000, 4'd2);
        chk_lock("R3 wrap to floor", 2, 2);
        look("R3 last slot hit", 32'h7000_abcd, 1'b1, 32'h0a00_abcd, 4'd2);
    endtask

    task automatic t_full;
        set_lock(7, 7);
        load(32'h7100_0000, 2'd2, 1'b1, 32'h0b00_0000, 4'd1);
        chk_lock("R4 R3 floor to top", 8, 8);
        look("R4 top slot", 32'h7100_0123, 1'b1, 32'h0b00_0123, 4'd1);
        load(32'h7200_0000, 2'd2, 1'b1, 32'h0c00_0000, 4'd1);
        chk("R5 busy preserved", {31'd0, saw_busy}, 32'd1);
        chk_lock("R5 lock kept", 8, 8);
        look("R5 not stored", 32'h7200_0000, 1'b0, '0, '0);
        load(32'h7300_0000, 2'd2, 1'b0, 32'h0d00_0000, 4'd1);
        chk("R5 busy ordinary", {31'd0, saw_busy}, 32'd1);
        look("R5 not stored b", 32'h7300_0000, 1'b0, '0, '0);
    endtask

    task automatic t_priority;
        run_op(OP_FLUSH_ALL);
        load(32'h3000_0000, 2'd3, 1'b0, 32'h1000_0000, 4'd1);
        load(32'h3000_1000, 2'd2, 1'b0, 32'h5000_0000, 4'd2);
        look("R12 lowest wins", 32'h3000_1234, 1'b1, 32'h1000_1234, 4'd1);
        set_lock(0, 0);
        run_op(OP_FLUSH_ONE);
        look("R12 next slot", 32'h3000_1234, 1'b1, 32'h5000_0234, 4'd2);
    endtask

    task automatic t_same_cycle;
        run_op(OP_FLUSH_ALL);
        @(negedge clk);
        ld_tag = 32'h4400_0000; ld_size = 2'd2; ld_prsvd = 1'b0;
        ld_pbase = 32'h0c00_0000; ld_attr = 4'd6;
        lk_va = 32'h4400_0044;
        ctl_op = OP_LOAD;
        @(posedge clk);
        @(negedge clk);
        ctl_op = 3'd0;
        chk("R13 before commit", {31'd0, lk_hit}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R13 after commit", {31'd0, lk_hit}, 32'd1);
        chk("R13 after commit pa", lk_pa, 32'h0c00_0044);
        set_lock(0, 0);
        @(negedge clk);
        ctl_op = OP_FLUSH_ONE;
        #1;
        chk("R13 before flush", {31'd0, lk_hit}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        ctl_op = 3'd0;
        chk("R13 after flush", {31'd0, lk_hit}, 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_load();
        t_mixed();
        t_read_scan();
        t_flush_one();
        t_flush_all();
        t_preserve();
        t_wrap();
        t_full();
        t_priority();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule